// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block turns the two phase-shifted channels of an incremental encoder into a 16-bit position value. The channels arrive asynchronously to the system clock. Each one passes through a two-flop synchronizer and then a stability filter. The filter lets a new level through only once three consecutive rising-edge samples agree, so short spikes from motor noise never reach the count logic.

The filtered pair is decoded at four counts per encoder cycle. Each legal Gray-code step moves the position up or down by one. The step is up when channel A leads channel B and down when B leads A. A step in which both channels move at once is illegal and is dropped.

For chaining an external counter, the block drives three outputs. A direction line is set one clock ahead of each count. A half-clock count pulse marks every count. A half-clock carry pulse marks the counts at which the position wraps through zero.

Top module: `quad_position_counter`

## Requirements
- R1: A level change on a channel reaches the decoder only after three consecutive rising-edge samples of the synchronized channel agree. A raw pulse that is sampled by only one or two rising edges produces no count.
- R2: Suppose a raw channel change is made shortly after rising edge E0 and then held. The position output shows the new value after rising edge E7, and it is unchanged after rising edge E6.
- R3: With the channel pair written as (A,B), the forward sequence 00, 10, 11, 01, 00 increments the position by one at each step, which is four counts per encoder cycle.
- R4: The reverse sequence 00, 01, 11, 10, 00, in which B leads A, decrements the position by one at each step.
- R5: The position is 16 bits wide and wraps. An up count from FFFFh gives 0000h, and a down count from 0000h gives FFFFh.
- R6: Each count produces exactly one count pulse. The pulse goes high just after the rising edge that updates the position and low just after the following falling edge.
- R7: A carry pulse with the same half-clock shape is produced only on the counts that wrap the position, in either direction. Non-wrapping counts produce none.
- R8: The direction output is 1 for up and 0 for down. It takes its new value one rising edge before the edge at which the pulse rises. It stays unchanged across that pulse edge and keeps its value until the next count is decoded.
- R9: A filtered transition in which A and B change in the same sample produces no count and no pulse. The decoder then resumes from the new state.
- R10: Driving the active-low reset low clears the position at once, without waiting for a clock. It sets direction to up and forces both pulses low. It returns the filters and the decoder to the idle state 00, so releasing reset with idle inputs produces no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_a_i | input | 1 | Encoder channel A, asynchronous |
| ch_b_i | input | 1 | Encoder channel B, asynchronous |
| pos_o | output | 16 | Current position count |
| dir_up_o | output | 1 | Direction of the most recent count, 1 = up |
| cnt_pulse_o | output | 1 | Half-clock pulse per count |
| carry_pulse_o | output | 1 | Half-clock pulse per wrapping count |

## Verification
The direction-stability property depends on the filter, not on any rule placed on the inputs. Reversing direction always means the channel that moved last moves back. That channel needs three agreeing samples, so two direction changes can never fall in adjacent cycles. The step-size and wrap properties assume nothing about the channels. The stimulus is nonetheless built so that every intended quadrature state is held for nine clocks, which keeps each count separate and checkable. Glitches are short, deliberate pulses that cover exactly one, two or three rising edges. The simultaneous-change case is driven on purpose, with both channels switched in the same instant.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Filtered channel pair; a is the upper bit.
    typedef struct packed {
        logic a;
        logic b;
    } chan_pair_t;

    // One decoded step handed from the decoder to the counter.
    typedef struct packed {
        logic valid;
        dir_e dir;
    } step_t;

    // Next state when channel A leads channel B.
    function automatic chan_pair_t fwd_next(chan_pair_t p);
        chan_pair_t n;
        n.a = ~p.b;
        n.b = p.a;
        return n;
    endfunction

    // Next state when channel B leads channel A.
    function automatic chan_pair_t rev_next(chan_pair_t p);
        chan_pair_t n;
        n.a = p.b;
        n.b = ~p.a;
        return n;
    endfunction

    // Classify a state change; a double change or no change yields no step.
    function automatic step_t classify(chan_pair_t prev, chan_pair_t curr);
        step_t s;
        s.valid = 1'b0;
        s.dir   = DIR_UP;
        if (curr == fwd_next(prev)) begin
            s.valid = 1'b1;
            s.dir   = DIR_UP;
        end else if (curr == rev_next(prev)) begin
            s.valid = 1'b1;
            s.dir   = DIR_DOWN;
        end
        return s;
    endfunction

endpackage

// File: rtl/qpc_chan_filter.sv
module qpc_chan_filter #(
    parameter int SYNC_STAGES    = 2,
    parameter int STABLE_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int HIST_W = STABLE_SAMPLES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST_W-1:0]      hist_q;
    logic                   smp;
    logic [STABLE_SAMPLES-1:0] window;
    logic                   filt_q;

    assign smp    = sync_q[SYNC_STAGES-1];
    assign window = {hist_q, smp};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= '0;
            filt_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            hist_q <= {hist_q[HIST_W-2:0], smp};
            if (&window) begin
                filt_q <= 1'b1;
            end else if (~|window) begin
                filt_q <= 1'b0;
            end
        end
    end

    assign filt_o = filt_q;

    generate
        if (STABLE_SAMPLES == 3) begin : g_chk3
            AST_FILTER_THREE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(filt_q) |-> ($past(smp, 1) == filt_q) && ($past(smp, 2) == filt_q)
                                     && ($past(smp, 3) == filt_q)); // R1
        end
    endgenerate

endmodule

// File: rtl/qpc_step_decode.sv
module qpc_step_decode
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_pair_t filt_i,
    output step_t      step_o,
    output dir_e       dir_o
);
    chan_pair_t prev_q;
    step_t      step_q;
    step_t      step_c;
    dir_e       dir_q;

    always_comb begin
        step_c = classify(prev_q, filt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            step_q <= '{valid: 1'b0, dir: DIR_UP};
            dir_q  <= DIR_UP;
        end else begin
            prev_q <= filt_i;
            step_q <= step_c;
            if (step_c.valid) begin
                dir_q <= step_c.dir;
            end
        end
    end

    assign step_o = step_q;
    assign dir_o  = dir_q;

    AST_STEP_MATCHES_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        step_q.valid |-> (dir_q == step_q.dir)); // R8

endmodule

// File: rtl/qpc_half_pulse.sv
module qpc_half_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    logic tog_rise_q;
    logic tog_fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_rise_q <= 1'b0;
        end else if (fire_i) begin
            tog_rise_q <= ~tog_rise_q;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_fall_q <= 1'b0;
        end else begin
            tog_fall_q <= tog_rise_q;
        end
    end

    assign pulse_o = tog_rise_q ^ tog_fall_q;

    AST_PULSE_LOW_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_o); // R6

endmodule

// File: rtl/qpc_pos_counter.sv
module qpc_pos_counter
    import qpc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_t            step_i,
    output logic [POS_W-1:0] pos_o,
    output logic             cnt_pulse_o,
    output logic             carry_pulse_o
);
    localparam logic [POS_W-1:0] POS_MAX = '1;
    localparam logic [POS_W-1:0] POS_MIN = '0;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_next;
    logic             wrap_c;
    logic             cnt_ev_q;
    logic             carry_ev_q;

    always_comb begin
        pos_next = pos_q;
        wrap_c   = 1'b0;
        if (step_i.valid) begin
            if (step_i.dir == DIR_UP) begin
                pos_next = pos_q + 1'b1;
                wrap_c   = (pos_q == POS_MAX);
            end else begin
                pos_next = pos_q - 1'b1;
                wrap_c   = (pos_q == POS_MIN);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q      <= '0;
            cnt_ev_q   <= 1'b0;
            carry_ev_q <= 1'b0;
        end else begin
            pos_q      <= pos_next;
            cnt_ev_q   <= step_i.valid;
            carry_ev_q <= wrap_c;
        end
    end

    qpc_half_pulse u_cnt_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (step_i.valid),
        .pulse_o (cnt_pulse_o)
    );

    qpc_half_pulse u_carry_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (wrap_c),
        .pulse_o (carry_pulse_o)
    );

    assign pos_o = pos_q;

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_q) |-> (pos_q == POS_W'($past(pos_q) + 1'b1))
                         || (pos_q == POS_W'($past(pos_q) - 1'b1))); // R5

    AST_MOVE_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_q) |-> cnt_ev_q); // R6

    AST_CARRY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        carry_ev_q |-> ((pos_q == POS_MIN) && ($past(pos_q) == POS_MAX))
                    || ((pos_q == POS_MAX) && ($past(pos_q) == POS_MIN))); // R7

endmodule

// File: rtl/quad_position_counter.sv
module quad_position_counter
    import qpc_pkg::*;
#(
    parameter int POS_W          = 16,
    parameter int SYNC_STAGES    = 2,
    parameter int STABLE_SAMPLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_a_i,
    input  logic             ch_b_i,
    output logic [POS_W-1:0] pos_o,
    output logic             dir_up_o,
    output logic             cnt_pulse_o,
    output logic             carry_pulse_o
);
    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0] raw_w;
    logic [NUM_CH-1:0] filt_w;
    chan_pair_t        filt_pair;
    step_t             step_w;
    dir_e              dir_w;

    assign raw_w = {ch_a_i, ch_b_i};

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
            qpc_chan_filter #(
                .SYNC_STAGES    (SYNC_STAGES),
                .STABLE_SAMPLES (STABLE_SAMPLES)
            ) u_filter (
                .clk    (clk),
                .rst_n  (rst_n),
                .raw_i  (raw_w[g]),
                .filt_o (filt_w[g])
            );
        end
    endgenerate

    assign filt_pair = chan_pair_t'(filt_w);

    qpc_step_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .filt_i (filt_pair),
        .step_o (step_w),
        .dir_o  (dir_w)
    );

    qpc_pos_counter #(
        .POS_W (POS_W)
    ) u_counter (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_i        (step_w),
        .pos_o         (pos_o),
        .cnt_pulse_o   (cnt_pulse_o),
        .carry_pulse_o (carry_pulse_o)
    );

    assign dir_up_o = (dir_w == DIR_UP);

    AST_DIR_SETUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_o) |-> $stable(dir_up_o)); // R8

    AST_DIR_MATCHES_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_o) |-> (dir_up_o == (pos_o == POS_W'($past(pos_o) + 1'b1)))); // R8

    AST_DOUBLE_CHANGE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_pair.a != $past(filt_pair.a)) && (filt_pair.b != $past(filt_pair.b)))
            |-> ##2 $stable(pos_o)); // R9

endmodule

// File: tb/test_quad_position_counter.sv
module test_quad_position_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_a = 1'b0;
    logic        ch_b = 1'b0;
    logic [15:0] pos;
    logic        dir_up;
    logic        cnt_pulse;
    logic        carry_pulse;

    int          checks = 0;
    int          errors = 0;
    int          cnt_seen = 0;
    int          carry_seen = 0;
    logic [15:0] exp_pos = 16'h0000;

    always #5 clk = ~clk;

    quad_position_counter i_quad_position_counter (
        .clk           (clk),
        .rst_n         (rst_n),
        .ch_a_i        (ch_a),
        .ch_b_i        (ch_b),
        .pos_o         (pos),
        .dir_up_o      (dir_up),
        .cnt_pulse_o   (cnt_pulse),
        .carry_pulse_o (carry_pulse)
    );

    always @(posedge cnt_pulse) cnt_seen++;
    always @(posedge carry_pulse) carry_seen++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic b);
        @(posedge clk);
        #3;
        ch_a = a;
        ch_b = b;
    endtask

    task automatic settle();
        repeat (9) @(posedge clk);
        #2;
    endtask

    task automatic move(input logic a, input logic b, input int delta, input string req);
        drive(a, b);
        settle();
        exp_pos = exp_pos + 16'(delta);
        chk(pos == exp_pos, req, "position after step", int'(pos), int'(exp_pos));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(pos == 16'h0, "R10", "position in reset", int'(pos), 0);
        chk(dir_up == 1'b1, "R10", "direction in reset", int'(dir_up), 1);
        chk(!cnt_pulse && !carry_pulse, "R10", "pulses in reset",
            int'({cnt_pulse, carry_pulse}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk(pos == 16'h0 && cnt_seen == 0, "R10", "no count on release",
            int'(pos) + cnt_seen, 0);
        exp_pos = 16'h0;
    endtask

    task automatic t_forward();
        int c0 = cnt_seen;
        int k0 = carry_seen;
        move(1'b1, 1'b0, 1, "R3");
        move(1'b1, 1'b1, 1, "R3");
        move(1'b0, 1'b1, 1, "R3");
        move(1'b0, 1'b0, 1, "R3");
        chk(dir_up == 1'b1, "R8", "direction after forward", int'(dir_up), 1);
        chk(cnt_seen - c0 == 4, "R6", "count pulses forward", cnt_seen - c0, 4);
        chk(carry_seen == k0, "R7", "no carry without wrap", carry_seen - k0, 0);
    endtask

    task automatic t_reverse();
        int c0 = cnt_seen;
        move(1'b0, 1'b1, -1, "R4");
        move(1'b1, 1'b1, -1, "R4");
        move(1'b1, 1'b0, -1, "R4");
        move(1'b0, 1'b0, -1, "R4");
        chk(dir_up == 1'b0, "R8", "direction after reverse", int'(dir_up), 0);
        chk(cnt_seen - c0 == 4, "R6", "count pulses reverse", cnt_seen - c0, 4);
    endtask

    task automatic t_timing();
        // state 00, direction currently down
        drive(1'b1, 1'b0);
        repeat (6) @(posedge clk);
        #2;
        chk(pos == exp_pos, "R2", "position unchanged after E6", int'(pos), int'(exp_pos));
        chk(dir_up == 1'b1, "R8", "direction set one clock ahead", int'(dir_up), 1);
        chk(cnt_pulse == 1'b0, "R6", "pulse low before update", int'(cnt_pulse), 0);
        @(posedge clk);
        #2;
        exp_pos = exp_pos + 16'd1;
        chk(pos == exp_pos, "R2", "position updated after E7", int'(pos), int'(exp_pos));
        chk(cnt_pulse == 1'b1, "R6", "pulse high in high phase", int'(cnt_pulse), 1);
        chk(dir_up == 1'b1, "R8", "direction at pulse", int'(dir_up), 1);
        #5;
        chk(cnt_pulse == 1'b0, "R6", "pulse low after falling edge", int'(cnt_pulse), 0);
        @(posedge clk);
        #2;
        chk(dir_up == 1'b1, "R8", "direction held one clock after", int'(dir_up), 1);
        chk(cnt_pulse == 1'b0, "R6", "single pulse", int'(cnt_pulse), 0);
        settle();
    endtask

    task automatic t_wrap();
        int k0;
        // state (1,0); restore to 00 with a down count
        move(1'b0, 1'b0, -1, "R4");
        chk(pos == 16'h0, "R5", "at zero before underflow", int'(pos), 0);
        k0 = carry_seen;
        drive(1'b0, 1'b1);
        repeat (7) @(posedge clk);
        #2;
        chk(pos == 16'hFFFF, "R5", "underflow wraps", int'(pos), 16'hFFFF);
        chk(carry_pulse == 1'b1, "R7", "carry high on underflow", int'(carry_pulse), 1);
        #5;
        chk(carry_pulse == 1'b0, "R7", "carry low after falling edge", int'(carry_pulse), 0);
        settle();
        exp_pos = 16'hFFFF;
        move(1'b0, 1'b0, 1, "R5");
        chk(pos == 16'h0, "R5", "overflow wraps", int'(pos), 0);
        chk(carry_seen - k0 == 2, "R7", "carry pulses over both wraps", carry_seen - k0, 2);
    endtask

    task automatic t_glitch();
        int c0 = cnt_seen;
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        settle();
        chk(pos == exp_pos, "R1", "one-edge pulse rejected", int'(pos), int'(exp_pos));
        drive(1'b1, 1'b0);
        @(posedge clk);
        drive(1'b0, 1'b0);
        settle();
        chk(pos == exp_pos, "R1", "two-edge pulse rejected", int'(pos), int'(exp_pos));
        drive(1'b0, 1'b1);
        @(posedge clk);
        drive(1'b0, 1'b0);
        settle();
        chk(cnt_seen == c0, "R1", "no pulses from glitches", cnt_seen - c0, 0);
        drive(1'b1, 1'b0);
        repeat (2) @(posedge clk);
        drive(1'b0, 1'b0);
        settle();
        chk(cnt_seen - c0 == 2, "R1", "three-edge pulse passes", cnt_seen - c0, 2);
        chk(pos == exp_pos, "R1", "up then down returns", int'(pos), int'(exp_pos));
    endtask

    task automatic t_illegal();
        int c0 = cnt_seen;
        move(1'b1, 1'b1, 0, "R9");
        move(1'b0, 1'b0, 0, "R9");
        chk(cnt_seen == c0, "R9", "no pulse on double change", cnt_seen - c0, 0);
        move(1'b1, 1'b1, 0, "R9");
        move(1'b0, 1'b1, 1, "R9");
        move(1'b0, 1'b0, 1, "R9");
    endtask

    task automatic t_async_reset();
        @(posedge clk);
        #4;
        rst_n = 1'b0;
        #1;
        chk(pos == 16'h0, "R10", "clear without clock edge", int'(pos), 0);
        chk(!cnt_pulse && !carry_pulse, "R10", "pulses low in reset",
            int'({cnt_pulse, carry_pulse}), 0);
        exp_pos = 16'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        begin
            int c0 = cnt_seen;
            settle();
            chk(pos == 16'h0 && cnt_seen == c0, "R10", "quiet release",
                int'(pos) + cnt_seen - c0, 0);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_forward();
        t_reverse();
        t_timing();
        t_wrap();
        t_glitch();
        t_illegal();
        t_async_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule